// File: doc/BRIEF.md
# Configurable Hardware Stack Pointer Unit

This block keeps the pointer of a call/return stack in memory and carries out push and pop on a small synchronous word memory that it owns. Two parameters choose the stack's layout: whether it grows toward higher or lower addresses, and whether the pointer marks the topmost occupied word or the first free word. Each of the four layouts has its own order of pointer step and memory access, and the block applies that order.

A request takes two cycles after it is accepted: one for the pointer step and one for the memory access, in the order the layout needs. While the sequence runs, `busy` is high and new requests are ignored. A push on a full stack or a pop on an empty stack is refused. The refusal shows as a one-cycle error pulse and the pointer does not move. A completed pop presents the word together with a one-cycle valid strobe.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, `sp` holds the empty value, and `busy`, `pop_valid`, `ovf_err` and `unf_err` are all low. The empty value is BASE-1 for upward/last-full, BASE for upward/next-empty, BASE+1 for downward/last-full and BASE for downward/next-empty.
- R2: A push is accepted at the edge where the block is idle, `push_req` is high and the stack is not full. In the last-full layout the pointer moves at the first edge after acceptance and the memory write happens at the second. In the next-empty layout the write happens first and the pointer moves at the second edge.
- R3: A pop is accepted when the block is idle, `pop_req` is high, `push_req` is low and the stack is not empty. In the next-empty layout the pointer moves back at the first edge after acceptance and the read happens at the second. In the last-full layout the read happens first and the pointer moves at the second edge.
- R4: Pops return the pushed words in reverse order of pushing.
- R5: `busy` is high for exactly the two cycles following an accepted request. `push_req`, `pop_req` and `push_data` are ignored while `busy` is high, and the word written is the one present at acceptance.
- R6: A push with DEPTH words stored is refused. `ovf_err` goes high for one cycle, `sp` does not change and stored data is not altered.
- R7: A pop on an empty stack is refused. `unf_err` goes high for one cycle, `sp` does not change and `pop_valid` stays low.
- R8: When `push_req` and `pop_req` are both high at an idle edge, the push is served and the pop is dropped.
- R9: Each pointer step is one word. The pointer moves up on a push when growing upward and down when growing downward, with pops doing the opposite. With n words stored, `sp` equals the empty value plus n (upward) or minus n (downward).
- R10: `pop_valid` is a one-cycle pulse, high in the cycle after the second edge of an accepted pop, and `pop_data` carries the popped word while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Request to push `push_data` |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | DATA_W | Word to push, taken at acceptance |
| busy | output | 1 | A two-step sequence is in progress |
| sp | output | ADDR_W | Current stack pointer |
| pop_data | output | DATA_W | Popped word |
| pop_valid | output | 1 | One-cycle strobe for `pop_data` |
| ovf_err | output | 1 | Push refused because the stack is full |
| unf_err | output | 1 | Pop refused because the stack is empty |

## Verification
The hardest case to reach is the full boundary combined with both requests at once: the stack has to be filled to exactly DEPTH words before a push, and before a simultaneous push and pop, can be refused. A directed phase fills the stack, hits both refusals and then drains it while checking the returned order. After that, random mixes of push, pop, both and idle are applied, and random request noise is driven throughout every busy window. Four instances, one per layout, receive the same stimulus, so the timing of each pointer step is compared across layouts cycle by cycle.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP1 = 2'd1,
    ST_STEP2 = 2'd2
  } seq_st_t;

  // Empty-stack pointer for a given layout.
  function automatic int empty_ptr(input int base, input bit grow_up, input bit last_full);
    if (!last_full) return base;
    return grow_up ? base - 1 : base + 1;
  endfunction

  // Pointer value once depth words are stored.
  function automatic int full_ptr(input int base, input bit grow_up, input bit last_full,
                                  input int depth);
    return grow_up ? empty_ptr(base, grow_up, last_full) + depth
                   : empty_ptr(base, grow_up, last_full) - depth;
  endfunction
endpackage

// File: rtl/sp_ptr.sv
module sp_ptr #(
  parameter int ADDR_W    = 6,
  parameter int BASE      = 16,
  parameter int DEPTH     = 8,
  parameter bit GROW_UP   = 1'b1,
  parameter bit LAST_FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,   // step taken by a push
  input  logic              ret_i,   // step taken by a pop
  output logic [ADDR_W-1:0] sp_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int EMPTY_I = sp_pkg::empty_ptr(BASE, GROW_UP, LAST_FULL);
  localparam int FULL_I  = sp_pkg::full_ptr(BASE, GROW_UP, LAST_FULL, DEPTH);
  localparam logic [ADDR_W-1:0] EMPTY_SP = EMPTY_I[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] FULL_SP  = FULL_I[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] sp_q, sp_d, sp_up, sp_dn;
  logic              sp_en;

  assign sp_up = sp_q + ONE;
  assign sp_dn = sp_q - ONE;
  assign sp_en = adv_i | ret_i;

  generate
    if (GROW_UP) begin : g_up
      always_comb sp_d = adv_i ? sp_up : sp_dn;
    end else begin : g_down
      always_comb sp_d = adv_i ? sp_dn : sp_up;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= EMPTY_SP;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp_o    = sp_q;
  assign empty_o = (sp_q == EMPTY_SP);
  assign full_o  = (sp_q == FULL_SP);

  p_one_word_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_q) |-> (sp_q == $past(sp_q) + ONE) || (sp_q == $past(sp_q) - ONE));
  p_no_step_past_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> !full_o);
  p_no_step_past_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |-> !empty_o);
endmodule

// File: rtl/sp_seq.sv
module sp_seq #(
  parameter bit LAST_FULL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_req_i,
  input  logic pop_req_i,
  input  logic empty_i,
  input  logic full_i,
  output logic busy_o,
  output logic take_data_o,
  output logic adv_o,
  output logic ret_o,
  output logic mem_we_o,
  output logic mem_re_o,
  output logic pop_valid_o,
  output logic ovf_err_o,
  output logic unf_err_o
);
  import sp_pkg::*;

  seq_st_t st_q, st_d;
  logic    is_pop_q, is_pop_d;
  logic    ovf_q, ovf_d, unf_q, unf_d, pv_q, pv_d;
  logic    ptr_first, ptr_phase, in_seq;

  always_comb begin
    st_d        = st_q;
    is_pop_d    = is_pop_q;
    ovf_d       = 1'b0;
    unf_d       = 1'b0;
    take_data_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (push_req_i) begin
          if (full_i) ovf_d = 1'b1;
          else begin
            st_d        = ST_STEP1;
            is_pop_d    = 1'b0;
            take_data_o = 1'b1;
          end
        end else if (pop_req_i) begin
          if (empty_i) unf_d = 1'b1;
          else begin
            st_d     = ST_STEP1;
            is_pop_d = 1'b1;
          end
        end
      end
      ST_STEP1: st_d = ST_STEP2;
      ST_STEP2: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // Last-full: push moves the pointer first, pop accesses first.
  // Next-empty: the reverse.
  assign ptr_first = is_pop_q ? !LAST_FULL : LAST_FULL;
  assign in_seq    = (st_q == ST_STEP1) || (st_q == ST_STEP2);
  assign ptr_phase = ((st_q == ST_STEP1) && ptr_first) || ((st_q == ST_STEP2) && !ptr_first);

  assign adv_o    = ptr_phase & !is_pop_q;
  assign ret_o    = ptr_phase &  is_pop_q;
  assign mem_we_o = in_seq & !ptr_phase & !is_pop_q;
  assign mem_re_o = in_seq & !ptr_phase &  is_pop_q;
  assign pv_d     = (st_q == ST_STEP2) & is_pop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      is_pop_q <= 1'b0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
      pv_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      is_pop_q <= is_pop_d;
      ovf_q    <= ovf_d;
      unf_q    <= unf_d;
      pv_q     <= pv_d;
    end
  end

  assign busy_o      = in_seq;
  assign pop_valid_o = pv_q;
  assign ovf_err_o   = ovf_q;
  assign unf_err_o   = unf_q;

  p_busy_two_cycles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> busy_o ##1 !busy_o);
  p_refusal_stays_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err_o || unf_err_o) |-> !busy_o);
  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid_o |=> !pop_valid_o);
  p_one_refusal_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_err_o && unf_err_o));
  p_one_action_per_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({adv_o, ret_o, mem_we_o, mem_re_o}) <= 1);
endmodule

// File: rtl/sp_mem.sv
module sp_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;

  p_no_rw_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> !re_i);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 8,
  parameter int BASE      = 16,
  parameter bit GROW_UP   = 1'b1,
  parameter bit LAST_FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] push_data,
  output logic              busy,
  output logic [ADDR_W-1:0] sp,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic              ovf_err,
  output logic              unf_err
);
  logic              empty_w, full_w, adv_w, ret_w, we_w, re_w, take_w;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (take_w) data_q <= push_data;
  end

  sp_seq #(.LAST_FULL(LAST_FULL)) u_seq (
    .clk(clk), .rst_n(rst_n), .push_req_i(push_req), .pop_req_i(pop_req),
    .empty_i(empty_w), .full_i(full_w), .busy_o(busy), .take_data_o(take_w),
    .adv_o(adv_w), .ret_o(ret_w), .mem_we_o(we_w), .mem_re_o(re_w),
    .pop_valid_o(pop_valid), .ovf_err_o(ovf_err), .unf_err_o(unf_err)
  );

  sp_ptr #(.ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH), .GROW_UP(GROW_UP),
           .LAST_FULL(LAST_FULL)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_w), .ret_i(ret_w),
    .sp_o(sp), .empty_o(empty_w), .full_o(full_w)
  );

  sp_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(we_w), .re_i(re_w), .addr_i(sp),
    .wdata_i(data_q), .rdata_o(pop_data)
  );

  p_sp_held_on_refusal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err || unf_err) |-> $stable(sp));
endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
  localparam int AW = 6, DW = 16, DEPTH = 8, NCFG = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, push_req, pop_req;
  logic [DW-1:0] push_data;
  logic          busy_o [NCFG];
  logic [AW-1:0] sp_o   [NCFG];
  logic [DW-1:0] pd_o   [NCFG];
  logic          pv_o   [NCFG];
  logic          ovf_o  [NCFG];
  logic          unf_o  [NCFG];

  // cfg 0: up/last-full, 1: up/next-empty, 2: down/last-full, 3: down/next-empty
  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam bit UP = (g < 2);
    localparam bit LF = ((g % 2) == 0);
    stack_ptr_unit #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .BASE(UP ? 16 : 47),
                     .GROW_UP(UP), .LAST_FULL(LF)) dut (
      .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
      .push_data(push_data), .busy(busy_o[g]), .sp(sp_o[g]), .pop_data(pd_o[g]),
      .pop_valid(pv_o[g]), .ovf_err(ovf_o[g]), .unf_err(unf_o[g])
    );
  end

  int n_tests = 0, n_fail = 0, cnt = 0;
  logic [DW-1:0] mdl [DEPTH];
  bit done = 0;

  function automatic int exp_sp(input int g, input int n);
    bit up = (g < 2);
    bit lf = ((g % 2) == 0);
    int e = up ? (lf ? 15 : 16) : (lf ? 48 : 47);
    return up ? e + n : e - n;
  endfunction

  function automatic bit ptr_first(input int g, input bit is_pop);
    bit lf = ((g % 2) == 0);
    return is_pop ? !lf : lf;
  endfunction

  task automatic chk(input string req, input int g, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cfg%0d: actual %0d expected %0d", req, g, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // kind: 0 push, 1 pop, 2 push and pop together
  task automatic op(input int kind, input logic [DW-1:0] d);
    bit is_pop = (kind == 1);
    bit refused;
    string rq;
    @(negedge clk);
    push_req  = (kind != 1);
    pop_req   = (kind != 0);
    push_data = d;
    @(negedge clk);
    refused = is_pop ? (cnt == 0) : (cnt == DEPTH);
    rq = (kind == 2) ? "R8" : (is_pop ? "R3" : "R2");
    if (refused) begin
      for (int g = 0; g < NCFG; g++) begin
        if (is_pop) begin
          chk("R7 unf_err", g, unf_o[g], 1);
          chk("R7 pop_valid", g, pv_o[g], 0);
          chk("R7 sp", g, sp_o[g], exp_sp(g, cnt));
        end else begin
          chk({rq, " R6 ovf_err"}, g, ovf_o[g], 1);
          chk({rq, " R6 sp"}, g, sp_o[g], exp_sp(g, cnt));
        end
        chk("R5 busy refused", g, busy_o[g], 0);
      end
      push_req = 0; pop_req = 0;
      return;
    end
    for (int g = 0; g < NCFG; g++) begin
      chk("R5 busy e0", g, busy_o[g], 1);
      chk({rq, " sp e0"}, g, sp_o[g], exp_sp(g, cnt));
      chk({rq, " no err"}, g, ovf_o[g] | unf_o[g], 0);
    end
    push_req = 1'($urandom); pop_req = 1'($urandom); push_data = 16'($urandom);
    @(negedge clk);
    for (int g = 0; g < NCFG; g++) begin
      chk("R5 busy e1", g, busy_o[g], 1);
      chk({rq, " sp e1 order"}, g, sp_o[g],
          exp_sp(g, ptr_first(g, is_pop) ? (is_pop ? cnt - 1 : cnt + 1) : cnt));
    end
    push_req = 1'($urandom); pop_req = 1'($urandom); push_data = 16'($urandom);
    @(negedge clk);
    if (is_pop) cnt--; else begin mdl[cnt] = d; cnt++; end
    for (int g = 0; g < NCFG; g++) begin
      chk("R5 busy e2", g, busy_o[g], 0);
      chk("R9 sp e2", g, sp_o[g], exp_sp(g, cnt));
      chk("R10 pop_valid", g, pv_o[g], is_pop);
      if (is_pop) chk("R4 pop_data", g, pd_o[g], mdl[cnt]);
    end
    push_req = 0; pop_req = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; push_req = 0; pop_req = 0; push_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int g = 0; g < NCFG; g++) begin
      chk("R1 sp", g, sp_o[g], exp_sp(g, 0));
      chk("R1 busy", g, busy_o[g], 0);
      chk("R1 flags", g, {pv_o[g], ovf_o[g], unf_o[g]}, 0);
    end
    op(1, '0);                                      // R7 underflow
    for (int i = 0; i < DEPTH; i++) op(0, 16'hA000 + 16'(i));
    op(0, 16'hDEAD);                                // R6 overflow
    op(2, 16'hBEEF);                                // R8 both while full
    for (int i = 0; i < DEPTH; i++) op(1, '0);      // R4 reverse order
    op(1, '0);
    op(2, 16'h1234);                                // R8 both, push served
    op(1, '0);
    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 4)      op(0, 16'($urandom));
      else if (k < 8) op(1, '0);
      else if (k < 9) op(2, 16'($urandom));
      else @(negedge clk);
    end
    finish_run();
  end
endmodule